// File: doc/BRIEF.md
# Gain Control Level Detector with Pulse-Width Output

This block sits at the front of a sampled receiver. It watches two 10-bit sample lanes, each carrying two samples per symbol. It reduces their magnitudes to one average level per fixed frame and turns that level into a single-bit pulse-width control signal. Outside the chip, a filter integrates the pulse train into the control voltage of an analog gain stage, which closes the gain loop.

Both lanes share one static format select, so the samples can be signed or offset-coded. At each frame boundary the block also compares the average level against an 8-bit static target and raises a flag when the level sits within fifteen percent of it. The flag and the pulse width change together, once per frame.

Top module: `agc_level_pwm`

## Requirements
- R1: With `fmt_sel` = 0 the samples are read as two's complement. With `fmt_sel` = 1 they are offset binary: code 512 is zero, codes above 512 are positive and codes below 512 are negative.
- R2: Each sample counts by its magnitude. The most negative code (-512 after conversion) counts as 511, so every magnitude fits in 9 bits.
- R3: A frame is 512 clock cycles (256 symbols). The first frame starts at the first rising edge after reset. The block adds up the magnitudes of both lanes on every cycle of the frame, and the frame level is floor(sum / 1024), a value from 0 to 511.
- R4: In the frame that follows, `gain_pwm` is high for exactly as many cycles as that frame level. The high time starts on the first cycle of the frame and is one contiguous pulse.
- R5: The pulse width and `level_ok` change only at frame boundaries. During the first frame after reset, `gain_pwm` stays low.
- R6: `level_ok` is set for the next frame when 20 × |level − `level_ref`| ≤ 3 × `level_ref`. `level_ref` is unsigned and is in the same units as the level. The equal case counts as inside the window.
- R7: Driving `rst_n` low forces `gain_pwm` and `level_ok` low at once and discards the partial sum. Counting starts afresh after release.
- R8: A level of 0 keeps `gain_pwm` low for the whole frame. A full-scale level of 511 keeps it high for 511 of the 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, two cycles per symbol |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| fmt_sel | input | 1 | Static sample format: 0 two's complement, 1 offset binary |
| samp_a | input | 10 | First sample lane |
| samp_b | input | 10 | Second sample lane |
| level_ref | input | 8 | Static target level |
| gain_pwm | output | 1 | Pulse-width control output, one pulse per frame |
| level_ok | output | 1 | Level within ±15 % of the target, held for one frame |

## Verification
The bench builds the block with its default parameters: 10-bit samples, 8-bit target, a 512-cycle frame and a 3/20 tolerance. With these values the frame level maps straight onto the pulse width. That puts the whole 0 to 511 width range within reach, including the all-low frame and the 511-cycle frame. The 8-bit target lets the bench hit both edges of the window exactly, at levels 85 and 115 against a target of 100. It also covers the clamped most-negative code in both formats.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;
  localparam int AGC_LANES = 2;

  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } agc_fmt_e;
endpackage

// File: rtl/agc_sample_mag.sv
`timescale 1ns/1ps
// Format conversion and saturated magnitude of one sample lane.
module agc_sample_mag
  import agc_pkg::*;
#(
  parameter int SAMP_W = 10
) (
  input  agc_fmt_e          fmt_i,
  input  logic [SAMP_W-1:0] samp_i,
  output logic [SAMP_W-2:0] mag_o
);
  localparam int MAG_W = SAMP_W - 1;
  localparam logic [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};
  localparam logic [SAMP_W-1:0] ONE      = {{(SAMP_W-1){1'b0}}, 1'b1};

  logic [SAMP_W-1:0] tc;
  logic [SAMP_W-1:0] negated;

  always_comb begin
    tc = samp_i;
    if (fmt_i == FMT_OFFSET) begin
      tc[SAMP_W-1] = ~samp_i[SAMP_W-1];
    end
    negated = (~tc) + ONE;
    if (!tc[SAMP_W-1]) begin
      mag_o = tc[MAG_W-1:0];
    end else if (tc == MOST_NEG) begin
      mag_o = '1;
    end else begin
      mag_o = negated[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/agc_frame_accum.sv
`timescale 1ns/1ps
// Frame phase counter and magnitude accumulator; LANES must be a power of two.
module agc_frame_accum #(
  parameter int MAG_W      = 9,
  parameter int FRAME_LOG2 = 9,
  parameter int LANES      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES*MAG_W-1:0] mag_i,
  output logic                   frame_done_o,
  output logic [FRAME_LOG2-1:0]  phase_o,
  output logic [MAG_W-1:0]       avg_o
);
  localparam int LANE_SH = $clog2(LANES);
  localparam int SUM_W   = MAG_W + LANE_SH + 1;
  localparam int ACC_W   = MAG_W + FRAME_LOG2 + LANE_SH;

  logic [FRAME_LOG2-1:0] phase_q, phase_d;
  logic [ACC_W-1:0]      acc_q, acc_d;
  logic [ACC_W-1:0]      total;
  logic [SUM_W-1:0]      lane_sum;

  always_comb begin
    lane_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_sum = lane_sum + SUM_W'(mag_i[l*MAG_W +: MAG_W]);
    end
    total        = acc_q + ACC_W'(lane_sum);
    frame_done_o = (phase_q == '1);
    phase_d      = phase_q + FRAME_LOG2'(1);
    acc_d        = frame_done_o ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
    end
  end

  assign phase_o = phase_q;
  assign avg_o   = total[ACC_W-1 -: MAG_W];

  // R3
  frame_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
endmodule

// File: rtl/agc_pwm_gen.sv
`timescale 1ns/1ps
// Width register and registered pulse comparator.
module agc_pwm_gen #(
  parameter int MAG_W      = 9,
  parameter int FRAME_LOG2 = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_done_i,
  input  logic [FRAME_LOG2-1:0] phase_i,
  input  logic [MAG_W-1:0]      avg_i,
  output logic                  pwm_o
);
  logic [FRAME_LOG2-1:0] width_new;
  logic [FRAME_LOG2-1:0] width_q, width_d;
  logic [FRAME_LOG2-1:0] phase_d;
  logic                  pwm_q, pwm_d;

  generate
    if (FRAME_LOG2 == MAG_W) begin : g_direct
      assign width_new = avg_i;
    end else if (FRAME_LOG2 > MAG_W) begin : g_widen
      assign width_new = {avg_i, {(FRAME_LOG2-MAG_W){1'b0}}};
    end else begin : g_narrow
      assign width_new = avg_i[MAG_W-1 -: FRAME_LOG2];
    end
  endgenerate

  always_comb begin
    width_d = width_q;
    if (frame_done_i) begin
      width_d = width_new;
    end
    phase_d = frame_done_i ? '0 : (phase_i + FRAME_LOG2'(1));
    pwm_d   = (phase_d < width_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      if (frame_done_i) begin
        width_q <= width_d;
      end
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R5
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_i |=> $stable(width_q));

  // R4
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(frame_done_i));
endmodule

// File: rtl/agc_window_chk.sv
`timescale 1ns/1ps
// Tolerance window compare of the frame level against the target.
module agc_window_chk #(
  parameter int MAG_W   = 9,
  parameter int REF_W   = 8,
  parameter int TOL_NUM = 3,
  parameter int TOL_DEN = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic [MAG_W-1:0] avg_i,
  input  logic [REF_W-1:0] ref_i,
  output logic             ok_o
);
  localparam int DIFF_W = (MAG_W > REF_W) ? MAG_W : REF_W;
  localparam int PROD_W = DIFF_W + $clog2(TOL_DEN + TOL_NUM + 1) + 1;

  logic [DIFF_W-1:0] lvl, tgt, diff;
  logic [PROD_W-1:0] lhs, rhs;
  logic              ok_q, ok_d;

  always_comb begin
    lvl  = DIFF_W'(avg_i);
    tgt  = DIFF_W'(ref_i);
    diff = (lvl >= tgt) ? (lvl - tgt) : (tgt - lvl);
    lhs  = PROD_W'(diff) * PROD_W'(TOL_DEN);
    rhs  = PROD_W'(tgt) * PROD_W'(TOL_NUM);
    ok_d = ok_q;
    if (frame_done_i) begin
      ok_d = (lhs <= rhs);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
    end else if (frame_done_i) begin
      ok_q <= ok_d;
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/agc_level_pwm.sv
`timescale 1ns/1ps
module agc_level_pwm
  import agc_pkg::*;
#(
  parameter int SAMP_W     = 10,
  parameter int REF_W      = 8,
  parameter int FRAME_LOG2 = 9,
  parameter int TOL_NUM    = 3,
  parameter int TOL_DEN    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_sel,
  input  logic [SAMP_W-1:0] samp_a,
  input  logic [SAMP_W-1:0] samp_b,
  input  logic [REF_W-1:0]  level_ref,
  output logic              gain_pwm,
  output logic              level_ok
);
  localparam int MAG_W = SAMP_W - 1;

  agc_fmt_e                    fmt_e;
  logic [AGC_LANES*SAMP_W-1:0] samp_bus;
  logic [AGC_LANES*MAG_W-1:0]  mag_bus;
  logic                        frame_done;
  logic [FRAME_LOG2-1:0]       phase;
  logic [MAG_W-1:0]            avg;

  assign fmt_e    = agc_fmt_e'(fmt_sel);
  assign samp_bus = {samp_b, samp_a};

  generate
    for (genvar l = 0; l < AGC_LANES; l++) begin : g_lane
      agc_sample_mag #(.SAMP_W(SAMP_W)) u_mag (
        .fmt_i  (fmt_e),
        .samp_i (samp_bus[l*SAMP_W +: SAMP_W]),
        .mag_o  (mag_bus[l*MAG_W +: MAG_W])
      );
    end
  endgenerate

  agc_frame_accum #(
    .MAG_W(MAG_W), .FRAME_LOG2(FRAME_LOG2), .LANES(AGC_LANES)
  ) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .mag_i        (mag_bus),
    .frame_done_o (frame_done),
    .phase_o      (phase),
    .avg_o        (avg)
  );

  agc_pwm_gen #(.MAG_W(MAG_W), .FRAME_LOG2(FRAME_LOG2)) u_pwm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done),
    .phase_i      (phase),
    .avg_i        (avg),
    .pwm_o        (gain_pwm)
  );

  agc_window_chk #(
    .MAG_W(MAG_W), .REF_W(REF_W), .TOL_NUM(TOL_NUM), .TOL_DEN(TOL_DEN)
  ) u_win (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done),
    .avg_i        (avg),
    .ref_i        (level_ref),
    .ok_o         (level_ok)
  );

  // R5
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(level_ok));
endmodule

// File: tb/tb_agc_level_pwm.sv
`timescale 1ns/1ps
module tb_agc_level_pwm;
  localparam int FRAME = 512;
  localparam int NFR   = 11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fmt_sel;
  logic [9:0] samp_a, samp_b;
  logic [7:0] level_ref;
  logic       gain_pwm, level_ok;

  int    checks = 0;
  int    errors = 0;
  bit    mon_done = 0;
  int    exp_w_q[$];
  bit    exp_ok_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  agc_level_pwm dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .samp_a(samp_a),
    .samp_b(samp_b), .level_ref(level_ref), .gain_pwm(gain_pwm),
    .level_ok(level_ok)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mag_of(input int code, input bit f);
    logic [9:0] t;
    int v;
    t = 10'(code);
    if (f) t[9] = ~t[9];
    v = int'($signed(t));
    if (v < 0) v = -v;
    if (v > 511) v = 511;
    return v;
  endfunction

  // Driver: pushes the expected result, then drives one frame.
  task automatic drive_frame(input int rf, input bit f, input int a0, input int a1,
                             input int b0, input int b1, input string tag);
    int sum, lvl, d;
    sum = 256 * (mag_of(a0, f) + mag_of(a1, f) + mag_of(b0, f) + mag_of(b1, f));
    lvl = sum / 1024;
    d   = (lvl > rf) ? lvl - rf : rf - lvl;
    exp_w_q.push_back(lvl);
    exp_ok_q.push_back(20 * d <= 3 * rf);
    exp_tag_q.push_back(tag);
    level_ref = 8'(rf);
    fmt_sel   = f;
    for (int i = 0; i < FRAME; i++) begin
      samp_a = (i % 2 == 0) ? 10'(a0) : 10'(a1);
      samp_b = (i % 2 == 0) ? 10'(b0) : 10'(b1);
      @(negedge clk);
    end
  endtask

  // Monitor: checks the first frame is low, then each displayed frame.
  initial begin
    int low_bad;
    @(posedge rst_n);
    low_bad = 0;
    for (int j = 0; j < FRAME; j++) begin
      if (gain_pwm) low_bad++;
      @(negedge clk);
    end
    check(low_bad == 0, "R5", "pwm high cycles in first frame", low_bad, 0);
    for (int k = 0; k < NFR; k++) begin
      int w, hi, mism, okbad;
      bit eok;
      string tag;
      w = exp_w_q.pop_front();
      eok = exp_ok_q.pop_front();
      tag = exp_tag_q.pop_front();
      hi = 0; mism = 0; okbad = 0;
      for (int j = 0; j < FRAME; j++) begin
        if (gain_pwm) hi++;
        if (gain_pwm != (j < w)) mism++;
        if (level_ok != eok) okbad++;
        @(negedge clk);
      end
      check(mism == 0, {tag, " R4 R5"}, "pwm high count/shape", hi, w);
      check(okbad == 0, {tag, " R6 R5"}, "level_ok", int'(!eok) ^ (okbad != 0 ? 1 : 0), int'(eok));
    end
    mon_done = 1;
  end

  initial begin
    int hi;
    rst_n = 1'b0; fmt_sel = 1'b0; samp_a = '0; samp_b = '0; level_ref = 8'd100;
    repeat (3) @(negedge clk);
    check(!gain_pwm && !level_ok, "R7", "outputs in reset", int'(gain_pwm) + int'(level_ok), 0);
    rst_n = 1'b1;
    drive_frame(100, 0,  100,  100, -100, -100, "R3");
    drive_frame(100, 0,  115,  115,  115,  115, "R6 upper edge");
    drive_frame(100, 0,  116,  116,  116,  116, "R6 above");
    drive_frame(100, 0,   85,   85,   85,   85, "R6 lower edge");
    drive_frame(100, 0,   84,   84,   84,   84, "R6 below");
    drive_frame(100, 1,  612,  612,  412,  412, "R1 offset");
    drive_frame(  0, 1,  512,  512,  512,  512, "R1 R8 zero");
    drive_frame(255, 0, -512, -512,  511,  511, "R2 R8 full");
    drive_frame( 60, 0,  200,  -40,    0,    0, "R3 alternating");
    drive_frame(  1, 0,    3,    3,    0,    0, "R3 truncation");
    drive_frame( 50, 1,    0, 1023,  461,  461, "R1 R2 offset extremes");
    wait (mon_done);
    samp_a = 10'd500; samp_b = 10'd500;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!gain_pwm && !level_ok, "R7", "outputs on mid-frame reset",
          int'(gain_pwm) + int'(level_ok), 0);
    repeat (3) @(negedge clk);
    samp_a = 10'd40; samp_b = 10'd40; fmt_sel = 1'b0;
    rst_n = 1'b1;
    repeat (FRAME) @(negedge clk);
    hi = 0;
    for (int j = 0; j < FRAME; j++) begin
      if (gain_pwm) hi++;
      @(negedge clk);
    end
    check(hi == 40, "R7", "width after reset restart", hi, 40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule